// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Selectable Rounding

This block performs one signed fractional multiply-accumulate per clock. Both operands are DW-bit two's-complement fractions, with the sign bit just left of the binary point, so each lies in [-1, 1). The full 2*DW-bit product, optionally shifted right by SHR places to trade precision for headroom, is sign-extended into an accumulator that carries GW guard bits above the product width. The accumulator is cleared, loaded with the product, or has the product added to it or subtracted from it.

A combinational narrowing path turns the accumulator into a DW-bit word for storage. The DW-1 low bits of the accumulator are discarded using truncation, round-half-up or convergent rounding. The rounded value is then clamped to the DW-bit range if saturation is on, or wrapped if it is off. A sticky flag records that a saturating store took place.

Top module: `fx_mac`

## Requirements
- R1: While rst_n is low, acc reads 0 and ovf reads 0.
- R2: With en high, op 2'b00 (clear) sets acc to 0 and clears ovf at the next rising edge.
- R3: With en high, op 2'b01 (load) sets acc to the sign-extended product a*b at the next rising edge.
- R4: With en high, op 2'b10 (add) sets acc to acc plus the product at the next edge. The accumulator wraps modulo 2^AW.
- R5: With en high, op 2'b11 (subtract) sets acc to acc minus the product at the next edge. The accumulator wraps modulo 2^AW.
- R6: With en low, acc and ovf hold their values whatever op, a, b and psh are.
- R7: With psh high, the product is shifted right arithmetically by SHR places (rounding toward minus infinity) before it is loaded, added or subtracted.
- R8: rnd_mode 2'b00 (truncate) gives result = floor(acc / 2^(DW-1)).
- R9: rnd_mode 2'b01 (round half up) gives result = floor((acc + 2^(DW-2)) / 2^(DW-1)).
- R10: rnd_mode 2'b10 and 2'b11 (convergent) round discarded fractions below one half down and above one half up. An exact half is rounded to whichever neighbour has a zero LSB.
- R11: With sat_en high, a rounded value above 2^(DW-1)-1 gives result 2^(DW-1)-1, and one below -2^(DW-1) gives -2^(DW-1). Rounding happens first.
- R12: With sat_en low, result is the low DW bits of the rounded value, and ovf is never set.
- R13: ovf is sticky. At a rising edge with en high and op not clear, it becomes set if sat_en is high and the rounded value of the current acc is out of range. Only a clear operation resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the accumulator and the flag |
| op | input | 2 | 00 clear, 01 load, 10 add, 11 subtract |
| a | input | DW | Signed fractional operand |
| b | input | DW | Signed fractional operand |
| psh | input | 1 | Shift the product right by SHR before use |
| rnd_mode | input | 2 | 00 truncate, 01 round half up, 1x convergent |
| sat_en | input | 1 | Clamp out-of-range results instead of wrapping |
| acc | output | 2*DW+GW | Accumulator contents |
| result | output | DW | Rounded, optionally clamped word |
| ovf | output | 1 | Sticky saturation flag |

## Verification
An operation driven in one cycle shows up in acc after exactly one rising edge. result follows acc, rnd_mode and sat_en combinationally with no further delay. ovf trails by one edge: it reflects the saturation state of the accumulator value that was present when the operation was applied. The bench applies each operation and samples acc and ovf a short time after the following edge. Within that same cycle, and before the next edge, it steps rnd_mode and sat_en through all eight combinations and compares result against its arithmetic model. It then restores the driven values so that the flag model sees the same settings as the design.

// File: rtl/fx_mac_pkg.sv
package fx_mac_pkg;

  typedef enum logic [1:0] {
    MAC_CLR  = 2'b00,
    MAC_LOAD = 2'b01,
    MAC_ADD  = 2'b10,
    MAC_SUB  = 2'b11
  } mac_op_e;

  typedef enum logic [1:0] {
    RND_TRUNC = 2'b00,
    RND_NEAR  = 2'b01,
    RND_CONV  = 2'b10,
    RND_CONV2 = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/fx_mac_mult.sv
module fx_mac_mult #(
  parameter int DW  = 16,
  parameter int GW  = 8,
  parameter int SHR = 2,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          psh,
  output logic [AW-1:0] addend
);

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = $signed(a) * $signed(b);
  assign prod_ext = {{GW{prod[PW-1]}}, prod};

  always_comb begin
    if (psh) addend = prod_ext >>> SHR;
    else     addend = prod_ext;
  end

endmodule

// File: rtl/fx_mac_accum.sv
module fx_mac_accum
  import fx_mac_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addend,
  output logic [AW-1:0] acc_q
);

  logic [AW-1:0] acc_d;

  always_comb begin
    unique case (mac_op_e'(op))
      MAC_CLR:  acc_d = '0;
      MAC_LOAD: acc_d = addend;
      MAC_ADD:  acc_d = acc_q + addend;
      MAC_SUB:  acc_d = acc_q - addend;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

endmodule

// File: rtl/fx_mac_narrow.sv
module fx_mac_narrow
  import fx_mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int FB = DW - 1,
  localparam int RW = AW - FB + 1
) (
  input  logic [AW-1:0] acc,
  input  logic [1:0]    rnd_mode,
  input  logic          sat_en,
  output logic [DW-1:0] result,
  output logic          sat_hit
);

  localparam logic signed [AW:0] HALF = (AW+1)'(1) << (FB - 1);
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [AW:0]   acc_x;
  logic signed [AW:0]   bias;
  logic signed [AW:0]   sum;
  logic        [RW-1:0] rnd_v;
  logic        [RW-DW:0] hi;
  logic                 in_range;

  assign acc_x = {acc[AW-1], acc};

  always_comb begin
    unique case (rnd_mode_e'(rnd_mode))
      RND_TRUNC: bias = '0;
      RND_NEAR:  bias = HALF;
      default:   bias = HALF - (AW+1)'(1) + (AW+1)'(acc[FB]);
    endcase
  end

  assign sum      = acc_x + bias;
  assign rnd_v    = sum[AW:FB];
  assign hi       = rnd_v[RW-1:DW-1];
  assign in_range = (&hi) | (~|hi);
  assign sat_hit  = sat_en & ~in_range;

  always_comb begin
    if (sat_hit) result = rnd_v[RW-1] ? MINV : MAXV;
    else         result = rnd_v[DW-1:0];
  end

endmodule

// File: rtl/fx_mac.sv
module fx_mac
  import fx_mac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int GW  = 8,
  parameter int SHR = 2,
  localparam int AW = 2 * DW + GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          psh,
  input  logic [1:0]    rnd_mode,
  input  logic          sat_en,
  output logic [AW-1:0] acc,
  output logic [DW-1:0] result,
  output logic          ovf
);

  logic [AW-1:0] addend;
  logic          sat_hit;
  logic          ovf_d;
  logic          ovf_q;

  fx_mac_mult #(.DW(DW), .GW(GW), .SHR(SHR)) u_mult (
    .a      (a),
    .b      (b),
    .psh    (psh),
    .addend (addend)
  );

  fx_mac_accum #(.AW(AW)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .op     (op),
    .addend (addend),
    .acc_q  (acc)
  );

  fx_mac_narrow #(.DW(DW), .AW(AW)) u_narrow (
    .acc      (acc),
    .rnd_mode (rnd_mode),
    .sat_en   (sat_en),
    .result   (result),
    .sat_hit  (sat_hit)
  );

  always_comb begin
    if (mac_op_e'(op) == MAC_CLR) ovf_d = 1'b0;
    else                          ovf_d = ovf_q | sat_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ovf_q <= 1'b0;
    else if (en) ovf_q <= ovf_d;
  end

  assign ovf = ovf_q;

endmodule

// File: rtl/fx_mac_chk.sv
module fx_mac_chk #(
  parameter int DW  = 16,
  parameter int GW  = 8,
  parameter int SHR = 2,
  localparam int AW = 2 * DW + GW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [1:0]    op,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic          psh,
  input logic [1:0]    rnd_mode,
  input logic          sat_en,
  input logic [AW-1:0] acc,
  input logic [DW-1:0] result,
  input logic          ovf
);

  logic signed [AW-1:0] chk_prod;
  assign chk_prod = $signed(a) * $signed(b);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'b00) |=> (acc == '0 && !ovf)); // R2

  AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'b01 && !psh) |=> ($signed(acc) == $past(chk_prod))); // R3

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc) && $stable(ovf))); // R6

  AST_TRUNC_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_mode == 2'b00 && !sat_en) |-> (result == acc[2*DW-2:DW-1])); // R8

  AST_FLAG_NEEDS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(sat_en)); // R12

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (ovf || $past(en && op == 2'b00))); // R13

endmodule

bind fx_mac fx_mac_chk #(.DW(DW), .GW(GW), .SHR(SHR)) u_chk (.*);

// File: tb/fx_mac_bench.sv
`timescale 1ns/100ps
module fx_mac_bench;

  localparam int DW  = 4;
  localparam int GW  = 3;
  localparam int SHR = 1;
  localparam int AW  = 2 * DW + GW;
  localparam int FB  = DW - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [1:0]    op;
  logic [DW-1:0] a, b;
  logic          psh;
  logic [1:0]    rnd_mode;
  logic          sat_en;
  logic [AW-1:0] acc;
  logic [DW-1:0] result;
  logic          ovf;

  int n_chk = 0;
  int n_bad = 0;
  int m_acc = 0;
  int m_ovf = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fx_mac #(.DW(DW), .GW(GW), .SHR(SHR)) u_fx_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b), .psh(psh),
    .rnd_mode(rnd_mode), .sat_en(sat_en), .acc(acc), .result(result), .ovf(ovf)
  );

  function automatic int wrapw(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  function automatic int rnd_val(int v, int rm);
    int q, r;
    q = v >>> FB;
    r = v & ((1 << FB) - 1);
    if (rm == 1) begin
      if (r >= (1 << (FB - 1))) q = q + 1;
    end else if (rm >= 2) begin
      if (r > (1 << (FB - 1))) q = q + 1;
      else if (r == (1 << (FB - 1))) q = q + (q & 1);
    end
    return q;
  endfunction

  function automatic bit out_rng(int v, int rm);
    int q;
    q = rnd_val(v, rm);
    return (q > (1 << (DW - 1)) - 1) || (q < -(1 << (DW - 1)));
  endfunction

  function automatic int narrow(int v, int rm, bit s);
    int q;
    q = rnd_val(v, rm);
    if (s && q > (1 << (DW - 1)) - 1) return (1 << (DW - 1)) - 1;
    if (s && q < -(1 << (DW - 1)))    return -(1 << (DW - 1));
    return wrapw(q, DW);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_op(bit e, int o, int ia, int ib, bit p, int rm, bit s);
    int prod;
    string req;
    en = e; op = 2'(o); a = DW'(ia); b = DW'(ib); psh = p;
    rnd_mode = 2'(rm); sat_en = s;
    prod = ia * ib;
    if (p) prod = prod >>> SHR;
    if (e) begin
      if (o == 0) m_ovf = 0;
      else if (s && out_rng(m_acc, rm)) m_ovf = 1;
      case (o)
        0: m_acc = 0;
        1: m_acc = prod;
        2: m_acc = wrapw(m_acc + prod, AW);
        default: m_acc = wrapw(m_acc - prod, AW);
      endcase
    end
    @(posedge clk);
    #2;
    if (!e)           req = "R6";
    else if (o == 0)  req = "R2";
    else if (p)       req = "R7";
    else if (o == 1)  req = "R3";
    else if (o == 2)  req = "R4";
    else              req = "R5";
    chk($signed(acc) == m_acc, {req, " acc"}, $signed(acc), m_acc);
    chk(int'(ovf) == m_ovf, e ? "R13 ovf" : "R6 ovf", int'(ovf), m_ovf);
    for (int rmi = 0; rmi < 4; rmi++) begin
      for (int si = 0; si < 2; si++) begin
        int exp;
        rnd_mode = 2'(rmi);
        sat_en   = si[0];
        #1;
        exp = narrow(m_acc, rmi, si[0]);
        if (si == 1 && out_rng(m_acc, rmi)) req = "R11";
        else if (si == 0 && out_rng(m_acc, rmi)) req = "R12";
        else if (rmi == 0) req = "R8";
        else if (rmi == 1) req = "R9";
        else req = "R10";
        chk($signed(result) == exp, {req, " result"}, $signed(result), exp);
      end
    end
  endtask

  initial begin
    en = 1'b0; op = 2'b00; a = '0; b = '0; psh = 1'b0;
    rnd_mode = 2'b00; sat_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk(acc == '0, "R1 acc", int'(acc), 0);
    chk(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // load every operand pair, mixed modes
    for (int ia = -8; ia < 8; ia++)
      for (int ib = -8; ib < 8; ib++)
        do_op(1, 1, ia, ib, 1'b0, (ia + 8) % 4, 1'((ib + 8) % 2));

    // accumulate every pair with saturation on, shift on odd sums
    do_op(1, 0, 0, 0, 1'b0, 0, 1'b0);
    for (int ia = -8; ia < 8; ia++)
      for (int ib = -8; ib < 8; ib++)
        do_op(1, 2, ia, ib, 1'((ia + ib + 16) % 2), (ib + 8) % 4, 1'b1);

    // disabled cycles must not move anything (R6)
    for (int k = 0; k < 8; k++)
      do_op(0, k % 4, 7, -8 + k, 1'(k % 2), k % 4, 1'b1);

    // clear drops flag (R2)
    do_op(1, 0, 3, 3, 1'b0, 0, 1'b1);

    // subtract every pair, saturation off: flag stays low (R12)
    for (int ia = -8; ia < 8; ia++)
      for (int ib = -8; ib < 8; ib++)
        do_op(1, 3, ia, ib, 1'((ia + 8) % 2), (ia + ib + 16) % 4, 1'b0);

    // exact-half convergent corners: load values hitting .5 boundaries
    do_op(1, 1, 1, 4, 1'b0, 2, 1'b1);
    do_op(1, 1, 3, 4, 1'b0, 2, 1'b1);
    do_op(1, 1, -3, 4, 1'b0, 2, 1'b1);
    do_op(1, 1, 7, 7, 1'b0, 1, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule